// File: doc/BRIEF.md
# Constant Off-Time Bridge Current Limiter

This block sits between the bridge control logic and the gate drivers of a half-bridge pair. Each output channel takes its own turn-on command and three digitized comparator results: an overcurrent trip at the regulation level, and hard-short detectors for the high-side and low-side switches. While a channel is commanded on, an overcurrent trip switches the output off for a fixed number of clock cycles. After that the output switches on again if the command is still present. This gives chopping with a constant off-time. Every turn-on opens a blanking window. Inside that window the short detectors are ignored, so switching spikes and the recovery of diode charge cannot latch the bridge off.

A short seen after blanking sends a one-cycle latch-off request to the fault controller. The channel then stays off until its command is withdrawn. A second, shared path turns a junction-temperature code in degrees into a current-limit threshold code. Below a knee temperature the threshold is nominal. Between the knee and a shutdown temperature it ramps down linearly to a floor value. Above the shutdown temperature an overtemperature flag is raised. All durations are clock-cycle parameters.

Top module: `chop_limiter`

## Requirements
- R1: A channel that is idle and sees its command high at a clock edge drives its output (drive_en=1) from that edge on. When the command is sampled low while the output is driven, the output is released at that edge.
- R2: When the overcurrent trip is sampled high while the output is driven, the output goes off at that edge and stays off for exactly OFF_CYC cycles. At the end of that time it is driven again if the command is high.
- R3: An overcurrent trip that arrives during the off-time has no effect. It neither extends nor restarts the off-time.
- R4: Every turn-on, including the one after an off-time, starts a window of BLANK_CYC cycles. A short input sampled inside that window causes no latch-off request and does not switch the output off.
- R5: A high-side or low-side short sampled after blanking, while the output is driven, raises latch_req for exactly one cycle. It also switches the output off until the command has been sampled low.
- R6: latch_req is never raised for a short that arrives during the off-time.
- R7: thr_code equals THR_NOM for temperatures at or below T_KNEE and THR_MIN at or above T_SHUT. In between it equals THR_NOM - floor((THR_NOM-THR_MIN)*(t-T_KNEE)/(T_SHUT-T_KNEE)). It follows temp_code with one cycle of latency.
- R8: overtemp is 1 exactly when the registered temperature is above T_SHUT. It has the same one-cycle latency.
- R9: The channels are independent. A trip on one channel does not change the output of another.
- R10: If the command is low when the off-time ends, the channel goes idle and its output stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| on_cmd | input | N_CH | Per-channel turn-on command |
| oc_trip | input | N_CH | Per-channel overcurrent comparator |
| short_hi | input | N_CH | Per-channel high-side hard-short comparator |
| short_lo | input | N_CH | Per-channel low-side hard-short comparator |
| temp_code | input | TEMP_W | Junction temperature, unsigned degrees |
| drive_en | output | N_CH | Per-channel output enable to the gate driver |
| latch_req | output | N_CH | One-cycle latch-off request to the fault controller |
| thr_code | output | THR_W | Current-limit threshold code (0.1 A units by default) |
| overtemp | output | 1 | Overtemperature shutdown flag |

## Verification
The bench builds the block with two channels, an off-time of 6 cycles and a blanking window of 4 cycles. With such short windows, every cycle at the edge of each window can be driven one at a time: the last blanked cycle, the first unblanked one, the last off cycle and the re-entry. The temperature parameters stay at their defaults of 160 to 175 degrees with a threshold ramp from 65 to 25. Both end points and several points on the ramp, where the result is rounded down, can therefore be checked against hand-computed values.

// File: rtl/cl_pkg.sv
package cl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_BLANK,
        PH_RUN,
        PH_OFF,
        PH_HALT
    } phase_e;

    // Threshold foldback: nominal below knee, floor above shutdown, linear between.
    function automatic int fold_thr(input int t, input int knee, input int shut,
                                    input int nom, input int floor_v);
        int r;
        if (t <= knee)
            r = nom;
        else if (t >= shut)
            r = floor_v;
        else
            r = nom - ((nom - floor_v) * (t - knee)) / (shut - knee);
        return r;
    endfunction

endpackage

// File: rtl/cl_chan.sv
module cl_chan
    import cl_pkg::*;
#(
    parameter int OFF_CYC   = 2500,
    parameter int BLANK_CYC = 2063
) (
    input  logic clk,
    input  logic rst,
    input  logic on_cmd,
    input  logic oc_trip,
    input  logic short_any,
    output logic drive_en,
    output logic latch_req
);
    localparam int MAXC = (OFF_CYC > BLANK_CYC) ? OFF_CYC : BLANK_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    phase_e        ph;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            cnt       <= '0;
            latch_req <= 1'b0;
        end else begin
            latch_req <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (on_cmd) begin
                        ph  <= PH_BLANK;
                        cnt <= CW'(BLANK_CYC - 1);
                    end
                end
                PH_BLANK: begin
                    if (!on_cmd) begin
                        ph <= PH_IDLE;
                    end else if (oc_trip) begin
                        ph  <= PH_OFF;
                        cnt <= CW'(OFF_CYC - 1);
                    end else if (cnt == '0) begin
                        ph <= PH_RUN;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_RUN: begin
                    if (!on_cmd) begin
                        ph <= PH_IDLE;
                    end else if (short_any) begin
                        ph        <= PH_HALT;
                        latch_req <= 1'b1;
                    end else if (oc_trip) begin
                        ph  <= PH_OFF;
                        cnt <= CW'(OFF_CYC - 1);
                    end
                end
                PH_OFF: begin
                    if (cnt == '0) begin
                        ph  <= on_cmd ? PH_BLANK : PH_IDLE;
                        cnt <= CW'(BLANK_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HALT: begin
                    if (!on_cmd) ph <= PH_IDLE;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign drive_en = (ph == PH_BLANK) || (ph == PH_RUN);

    p_turn_on_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_en) |-> $past(on_cmd));
    p_trip_off_r2: assert property (@(posedge clk) disable iff (rst)
        (drive_en && on_cmd && oc_trip && !(ph == PH_RUN && short_any)) |=> !drive_en);
    p_off_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_OFF && cnt != '0) |=> (ph == PH_OFF));
    p_blank_mask_r4: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_BLANK) |=> !latch_req);
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        latch_req |=> !latch_req);
    p_off_no_req_r6: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_OFF) |=> !latch_req);

endmodule

// File: rtl/cl_foldback.sv
module cl_foldback
    import cl_pkg::*;
#(
    parameter int TEMP_W  = 8,
    parameter int THR_W   = 8,
    parameter int T_KNEE  = 160,
    parameter int T_SHUT  = 175,
    parameter int THR_NOM = 65,
    parameter int THR_MIN = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TEMP_W-1:0] temp_code,
    output logic [THR_W-1:0]  thr_code,
    output logic              overtemp
);
    localparam logic [THR_W-1:0] NOM_C = THR_W'(THR_NOM);
    localparam logic [THR_W-1:0] MIN_C = THR_W'(THR_MIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_code <= NOM_C;
            overtemp <= 1'b0;
        end else begin
            thr_code <= THR_W'(fold_thr(int'(temp_code), T_KNEE, T_SHUT, THR_NOM, THR_MIN));
            overtemp <= (int'(temp_code) > T_SHUT);
        end
    end

    p_thr_range_r7: assert property (@(posedge clk) disable iff (rst)
        (thr_code >= MIN_C) && (thr_code <= NOM_C));
    p_ot_floor_r8: assert property (@(posedge clk) disable iff (rst)
        overtemp |-> (thr_code == MIN_C));

endmodule

// File: rtl/chop_limiter.sv
module chop_limiter
    import cl_pkg::*;
#(
    parameter int N_CH      = 2,
    parameter int OFF_CYC   = 2500,
    parameter int BLANK_CYC = 2063,
    parameter int TEMP_W    = 8,
    parameter int THR_W     = 8,
    parameter int T_KNEE    = 160,
    parameter int T_SHUT    = 175,
    parameter int THR_NOM   = 65,
    parameter int THR_MIN   = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CH-1:0]   on_cmd,
    input  logic [N_CH-1:0]   oc_trip,
    input  logic [N_CH-1:0]   short_hi,
    input  logic [N_CH-1:0]   short_lo,
    input  logic [TEMP_W-1:0] temp_code,
    output logic [N_CH-1:0]   drive_en,
    output logic [N_CH-1:0]   latch_req,
    output logic [THR_W-1:0]  thr_code,
    output logic              overtemp
);
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        cl_chan #(
            .OFF_CYC  (OFF_CYC),
            .BLANK_CYC(BLANK_CYC)
        ) u_chan (
            .clk      (clk),
            .rst      (rst),
            .on_cmd   (on_cmd[g]),
            .oc_trip  (oc_trip[g]),
            .short_any(short_hi[g] | short_lo[g]),
            .drive_en (drive_en[g]),
            .latch_req(latch_req[g])
        );
    end

    cl_foldback #(
        .TEMP_W (TEMP_W),
        .THR_W  (THR_W),
        .T_KNEE (T_KNEE),
        .T_SHUT (T_SHUT),
        .THR_NOM(THR_NOM),
        .THR_MIN(THR_MIN)
    ) u_fold (
        .clk      (clk),
        .rst      (rst),
        .temp_code(temp_code),
        .thr_code (thr_code),
        .overtemp (overtemp)
    );

endmodule

// File: tb/tb_chop_limiter.sv
module tb_chop_limiter;
    localparam int N = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] on_cmd = '0, oc_trip = '0, short_hi = '0, short_lo = '0;
    logic [7:0]   temp_code = 8'd25;
    logic [N-1:0] drive_en, latch_req;
    logic [7:0]   thr_code;
    logic         overtemp;

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic [N-1:0] de;
        logic [N-1:0] lr;
        string        tag;
    } exp_t;
    exp_t q[$];
    exp_t e;

    always #4 clk = ~clk;

    chop_limiter #(
        .N_CH(N), .OFF_CYC(6), .BLANK_CYC(4)
    ) dut (
        .clk(clk), .rst(rst), .on_cmd(on_cmd), .oc_trip(oc_trip),
        .short_hi(short_hi), .short_lo(short_lo), .temp_code(temp_code),
        .drive_en(drive_en), .latch_req(latch_req),
        .thr_code(thr_code), .overtemp(overtemp)
    );

    // Monitor: compares each expected item 2 ns after the edge that produced it.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (drive_en !== e.de || latch_req !== e.lr) begin
                errors++;
                $display("FAIL %s: drive_en=%b latch_req=%b expected drive_en=%b latch_req=%b",
                         e.tag, drive_en, latch_req, e.de, e.lr);
            end
        end
    end

    // Driver: sets inputs for one edge and pushes the outputs expected after it.
    task automatic step(input logic [N-1:0] on, input logic [N-1:0] oc,
                        input logic [N-1:0] sh, input logic [N-1:0] sl,
                        input logic [N-1:0] ede, input logic [N-1:0] elr,
                        input string tag);
        exp_t x;
        @(negedge clk);
        on_cmd = on; oc_trip = oc; short_hi = sh; short_lo = sl;
        x.de = ede; x.lr = elr; x.tag = tag;
        q.push_back(x);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic tchk(input logic [7:0] t, input logic [7:0] ethr, input logic eot,
                        input string tag);
        @(negedge clk);
        temp_code = t;
        @(negedge clk);
        chk({tag, " thr"}, 32'(thr_code), 32'(ethr));
        chk({tag, " ot"}, 32'(overtemp), 32'(eot));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("reset drive_en", 32'(drive_en), 0);
        chk("reset latch_req", 32'(latch_req), 0);
        chk("reset thr R7", 32'(thr_code), 65);
        chk("reset overtemp R8", 32'(overtemp), 0);
        rst = 1'b0;

        step(2'b01, 0, 0, 0, 2'b01, 0, "R1 turn-on");
        step(2'b01, 0, 2'b01, 0, 2'b01, 0, "R4 blank hs short 1");
        step(2'b01, 0, 0, 2'b01, 2'b01, 0, "R4 blank ls short 2");
        step(2'b01, 0, 0, 2'b01, 2'b01, 0, "R4 blank ls short 3");
        step(2'b01, 0, 0, 2'b01, 2'b01, 0, "R4 blank last cycle");
        step(2'b01, 0, 0, 0, 2'b01, 0, "R1 run");
        step(2'b01, 2'b01, 0, 0, 2'b00, 0, "R2 trip off");
        step(2'b01, 2'b01, 0, 0, 2'b00, 0, "R3 retrip ignored");
        step(2'b01, 0, 2'b01, 0, 2'b00, 0, "R6 short in off-time");
        step(2'b01, 0, 0, 0, 2'b00, 0, "R2 off 4");
        step(2'b01, 0, 0, 0, 2'b00, 0, "R2 off 5");
        step(2'b01, 0, 0, 0, 2'b00, 0, "R3 off 6 not extended");
        step(2'b01, 0, 0, 0, 2'b01, 0, "R2 resume");
        step(2'b01, 0, 2'b01, 0, 2'b01, 0, "R4 reblank short");
        step(2'b01, 0, 0, 0, 2'b01, 0, "R4 reblank 2");
        step(2'b01, 0, 0, 0, 2'b01, 0, "R4 reblank 3");
        step(2'b01, 0, 0, 0, 2'b01, 0, "R4 reblank 4");
        step(2'b01, 0, 0, 2'b01, 2'b00, 2'b01, "R5 ls short latch");
        step(2'b01, 0, 0, 2'b01, 2'b00, 0, "R5 single pulse");
        step(2'b01, 0, 0, 0, 2'b00, 0, "R5 held off");
        step(2'b00, 0, 0, 0, 2'b00, 0, "R5 release");
        step(2'b01, 0, 0, 0, 2'b01, 0, "R1 on again");
        step(2'b00, 0, 0, 0, 2'b00, 0, "R1 off at drop");
        step(2'b01, 0, 0, 0, 2'b01, 0, "R10 on");
        step(2'b01, 2'b01, 0, 0, 2'b00, 0, "R10 trip in blank");
        for (int i = 0; i < 5; i++)
            step(2'b00, 0, 0, 0, 2'b00, 0, "R10 off cmd low");
        step(2'b00, 0, 0, 0, 2'b00, 0, "R10 end idle");
        step(2'b00, 0, 0, 0, 2'b00, 0, "R10 stays idle");
        step(2'b01, 0, 0, 0, 2'b01, 0, "R4 fresh on");
        for (int i = 0; i < 4; i++)
            step(2'b01, 0, 0, 0, 2'b01, 0, "R4 fresh blank");
        step(2'b01, 0, 2'b01, 0, 2'b00, 2'b01, "R5 hs short latch");
        step(2'b00, 0, 0, 0, 2'b00, 0, "R5 release hs");
        step(2'b11, 0, 0, 0, 2'b11, 0, "R9 both on");
        step(2'b11, 2'b10, 0, 0, 2'b01, 0, "R9 ch1 trip only");
        step(2'b11, 0, 0, 0, 2'b01, 0, "R9 ch0 unaffected");
        step(2'b00, 0, 0, 0, 2'b00, 0, "R9 release");
        @(negedge clk);
        @(negedge clk);

        tchk(8'd100, 8'd65, 1'b0, "R7 cool");
        tchk(8'd160, 8'd65, 1'b0, "R7 knee");
        tchk(8'd161, 8'd63, 1'b0, "R7 ramp 161");
        tchk(8'd167, 8'd47, 1'b0, "R7 ramp 167");
        tchk(8'd174, 8'd28, 1'b0, "R7 ramp 174");
        tchk(8'd175, 8'd25, 1'b0, "R8 at shut");
        tchk(8'd176, 8'd25, 1'b1, "R8 above shut");
        tchk(8'd255, 8'd25, 1'b1, "R8 max");
        tchk(8'd150, 8'd65, 1'b0, "R8 recover");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule